// File: doc/BRIEF.md
# Page-Table Entry Memory-Type Validator

This block sits beside a page-table walker and examines each 64-bit Sv39-style entry as it returns from memory. It decides whether the entry must raise a page fault. The decision covers the basic validity flags and the reserved bits. Most of all, it covers the 2-bit page-based memory-type code that the entry carries. The walker raises a strobe with the entry and the effective memory-type enable bit. One clock later the block returns a registered result: a fault flag, a leaf/pointer flag and the memory-type code. The walker copies that code into its TLB refill record.

A synthesis-time parameter selects whether the design supports the memory-type feature. When the feature is compiled out, the code field is treated as reserved. Any non-zero value in it then faults, so the block behaves like a walker that has no such field.

Top module: `pte_mtype_check`

## Requirements
- R1: While reset is asserted, `res_vld_o` and `fault_o` are 0.
- R2: `res_vld_o` is 1 exactly in the cycle after a cycle with `pte_vld_i` high. When no strobe arrives, `fault_o`, `leaf_o` and `mtype_o` hold their previous values.
- R3: `leaf_o` reports whether the entry is a leaf. An entry is a leaf when bit 1 (read) or bit 3 (execute) is set. Otherwise it is a pointer.
- R4: An entry faults when bit 0 (valid) is 0. It also faults when bit 2 (write) is 1 while bit 1 (read) is 0.
- R5: An entry faults when any bit of the reserved field [60:54] is 1.
- R6: With the feature present, a leaf whose memory-type code (bits [62:61]) is 2'b11 faults, whatever the enable bit is.
- R7: With the feature present, a leaf with a non-zero code faults when `mt_en_i` is 0. A leaf with code 2'b01 or 2'b10 is accepted when `mt_en_i` is 1.
- R8: A pointer entry with a non-zero code faults, whatever the enable bit is.
- R9: With the feature parameter at 0, any non-zero code faults for leaves and pointers alike, and `mt_en_i` has no effect.
- R10: `mtype_o` carries bits [62:61] of a non-faulting entry and is 2'b00 for a faulting one. Bits 63 and [53:4] have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pte_vld_i | input | 1 | Entry-valid strobe |
| pte_i | input | 64 | Page-table entry under test |
| mt_en_i | input | 1 | Effective memory-type enable for the current privilege context |
| res_vld_o | output | 1 | Result valid, one cycle after the strobe |
| fault_o | output | 1 | Entry must raise a page fault |
| leaf_o | output | 1 | Entry is a leaf (1) or a pointer (0) |
| mtype_o | output | 2 | Memory-type code for the TLB refill, zero on a fault |

## Verification
The assertions take the strobe to be a plain single-cycle qualifier. They take `pte_i` and `mt_en_i` to be stable and known in every cycle where `pte_vld_i` is high. The assertions do not expect the walker to pace the strobes, so back-to-back strobes are legal. The stimulus drives inputs only on the falling clock edge and keeps them defined at all times. It mixes single strobes with idle gaps, so that both the hold behaviour and the one-cycle result timing are exercised. The random entries keep the reserved field zero most of the time, so that the memory-type rules are not always masked by a reserved-bit fault.

// File: rtl/pte_mtype_pkg.sv
package pte_mtype_pkg;

  // Flag bit positions within an entry (fixed by the page-table format).
  localparam int unsigned FLAG_V = 0;
  localparam int unsigned FLAG_R = 1;
  localparam int unsigned FLAG_W = 2;
  localparam int unsigned FLAG_X = 3;
  localparam int unsigned FLAG_N = 4;

  typedef struct packed {
    logic ex;
    logic wr;
    logic rd;
    logic vld;
  } pte_flags_t;

  typedef enum logic {
    PTE_POINTER = 1'b0,
    PTE_LEAF    = 1'b1
  } pte_kind_e;

endpackage

// File: rtl/pte_field_decode.sv
module pte_field_decode
  import pte_mtype_pkg::*;
#(
  parameter int unsigned PTE_W   = 64,
  parameter int unsigned MT_LSB  = 61,
  parameter int unsigned MT_W    = 2,
  parameter int unsigned RSV_LSB = 54,
  parameter int unsigned RSV_W   = 7
) (
  input  logic [PTE_W-1:0] pte_i,
  output pte_flags_t       flags_o,
  output pte_kind_e        kind_o,
  output logic [MT_W-1:0]  mt_o,
  output logic             rsv_nz_o
);

  localparam int unsigned MT_MSB  = MT_LSB + MT_W - 1;
  localparam int unsigned RSV_MSB = RSV_LSB + RSV_W - 1;

  logic [RSV_W-1:0] rsv_field;
  logic             unused_bits;

  always_comb begin
    flags_o.vld = pte_i[FLAG_V];
    flags_o.rd  = pte_i[FLAG_R];
    flags_o.wr  = pte_i[FLAG_W];
    flags_o.ex  = pte_i[FLAG_X];
    kind_o      = (pte_i[FLAG_R] || pte_i[FLAG_X]) ? PTE_LEAF : PTE_POINTER;
    mt_o        = pte_i[MT_MSB:MT_LSB];
    rsv_field   = pte_i[RSV_MSB:RSV_LSB];
    rsv_nz_o    = |rsv_field;
  end

  // Address, software and accessed/dirty bits play no part in the checks.
  assign unused_bits = ^{pte_i[PTE_W-1:MT_MSB+1], pte_i[RSV_LSB-1:FLAG_N]};

endmodule

// File: rtl/pte_mtype_rule.sv
module pte_mtype_rule
  import pte_mtype_pkg::*;
#(
  parameter int unsigned MT_W       = 2,
  parameter bit          FEATURE_EN = 1'b1
) (
  input  pte_kind_e       kind_i,
  input  logic [MT_W-1:0] mt_i,
  input  logic            mt_en_i,
  output logic            mt_fault_o
);

  localparam logic [MT_W-1:0] MT_RSVD = {MT_W{1'b1}};

  logic mt_nz;
  assign mt_nz = |mt_i;

  generate
    if (FEATURE_EN) begin : g_feature
      always_comb begin
        if (kind_i == PTE_LEAF) begin
          mt_fault_o = (mt_i == MT_RSVD) || (mt_nz && !mt_en_i);
        end else begin
          mt_fault_o = mt_nz;
        end
      end
    end else begin : g_no_feature
      logic unused_ctl;
      assign unused_ctl = mt_en_i ^ kind_i;
      assign mt_fault_o = mt_nz;
    end
  endgenerate

endmodule

// File: rtl/pte_result_reg.sv
module pte_result_reg #(
  parameter int unsigned MT_W = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic            fault_d_i,
  input  logic            leaf_d_i,
  input  logic [MT_W-1:0] mt_d_i,
  output logic            res_vld_o,
  output logic            fault_o,
  output logic            leaf_o,
  output logic [MT_W-1:0] mt_o
);

  logic            vld_q, vld_n;
  logic            fault_q, fault_n;
  logic            leaf_q, leaf_n;
  logic [MT_W-1:0] mt_q, mt_n;

  always_comb begin
    vld_n   = load_i;
    fault_n = fault_q;
    leaf_n  = leaf_q;
    mt_n    = mt_q;
    if (load_i) begin
      fault_n = fault_d_i;
      leaf_n  = leaf_d_i;
      mt_n    = mt_d_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q   <= 1'b0;
      fault_q <= 1'b0;
      leaf_q  <= 1'b0;
      mt_q    <= '0;
    end else begin
      vld_q   <= vld_n;
      fault_q <= fault_n;
      leaf_q  <= leaf_n;
      mt_q    <= mt_n;
    end
  end

  assign res_vld_o = vld_q;
  assign fault_o   = fault_q;
  assign leaf_o    = leaf_q;
  assign mt_o      = mt_q;

endmodule

// File: rtl/pte_mtype_check.sv
module pte_mtype_check
  import pte_mtype_pkg::*;
#(
  parameter int unsigned PTE_W      = 64,
  parameter int unsigned MT_LSB     = 61,
  parameter int unsigned MT_W       = 2,
  parameter int unsigned RSV_LSB    = 54,
  parameter int unsigned RSV_W      = 7,
  parameter bit          FEATURE_EN = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pte_vld_i,
  input  logic [PTE_W-1:0] pte_i,
  input  logic             mt_en_i,
  output logic             res_vld_o,
  output logic             fault_o,
  output logic             leaf_o,
  output logic [MT_W-1:0]  mtype_o
);

  pte_flags_t      flags;
  pte_kind_e       kind;
  logic [MT_W-1:0] mt_raw;
  logic            rsv_nz;
  logic            mt_fault;
  logic            base_fault;
  logic            any_fault;
  logic [MT_W-1:0] mt_gated;

  pte_field_decode #(
    .PTE_W  (PTE_W),
    .MT_LSB (MT_LSB),
    .MT_W   (MT_W),
    .RSV_LSB(RSV_LSB),
    .RSV_W  (RSV_W)
  ) u_decode (
    .pte_i   (pte_i),
    .flags_o (flags),
    .kind_o  (kind),
    .mt_o    (mt_raw),
    .rsv_nz_o(rsv_nz)
  );

  pte_mtype_rule #(
    .MT_W      (MT_W),
    .FEATURE_EN(FEATURE_EN)
  ) u_rule (
    .kind_i    (kind),
    .mt_i      (mt_raw),
    .mt_en_i   (mt_en_i),
    .mt_fault_o(mt_fault)
  );

  always_comb begin
    base_fault = !flags.vld || (flags.wr && !flags.rd) || rsv_nz;
    any_fault  = base_fault || mt_fault;
    mt_gated   = any_fault ? '0 : mt_raw;
  end

  logic unused_ex;
  assign unused_ex = flags.ex;

  pte_result_reg #(
    .MT_W(MT_W)
  ) u_result (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (pte_vld_i),
    .fault_d_i(any_fault),
    .leaf_d_i (kind == PTE_LEAF),
    .mt_d_i   (mt_gated),
    .res_vld_o(res_vld_o),
    .fault_o  (fault_o),
    .leaf_o   (leaf_o),
    .mt_o     (mtype_o)
  );

endmodule

// File: rtl/pte_mtype_check_sva.sv
module pte_mtype_check_sva #(
  parameter int unsigned PTE_W      = 64,
  parameter int unsigned MT_LSB     = 61,
  parameter int unsigned MT_W       = 2,
  parameter int unsigned RSV_LSB    = 54,
  parameter int unsigned RSV_W      = 7,
  parameter bit          FEATURE_EN = 1'b1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             pte_vld_i,
  input logic [PTE_W-1:0] pte_i,
  input logic             mt_en_i,
  input logic             res_vld_o,
  input logic             fault_o,
  input logic             leaf_o,
  input logic [MT_W-1:0]  mtype_o
);

  localparam int unsigned MT_MSB  = MT_LSB + MT_W - 1;
  localparam int unsigned RSV_MSB = RSV_LSB + RSV_W - 1;

  // R1
  always_comb begin
    if (!rst_ni) begin
      reset_clear_chk: assert (!res_vld_o && !fault_o);
    end
  end

  // R2
  res_vld_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pte_vld_i |=> res_vld_o);

  // R2
  res_vld_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pte_vld_i |=> !res_vld_o);

  // R2
  result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pte_vld_i |=> ($stable(fault_o) && $stable(leaf_o) && $stable(mtype_o)));

  // R3
  leaf_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pte_vld_i |=> (leaf_o == ($past(pte_i[1]) || $past(pte_i[3]))));

  // R4
  invalid_fault_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pte_vld_i && (!pte_i[0] || (pte_i[2] && !pte_i[1]))) |=> fault_o);

  // R5
  reserved_fault_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pte_vld_i && (|pte_i[RSV_MSB:RSV_LSB])) |=> fault_o);

  // R6
  leaf_rsvd_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pte_vld_i && (pte_i[1] || pte_i[3]) && (&pte_i[MT_MSB:MT_LSB])) |=> fault_o);

  // R7
  leaf_disabled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pte_vld_i && !mt_en_i && (|pte_i[MT_MSB:MT_LSB])) |=> fault_o);

  // R8
  pointer_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pte_vld_i && !pte_i[1] && !pte_i[3] && (|pte_i[MT_MSB:MT_LSB])) |=> fault_o);

  // R9
  no_feature_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((FEATURE_EN == 1'b0) && pte_vld_i && (|pte_i[MT_MSB:MT_LSB])) |=> fault_o);

  // R10
  fault_zero_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_vld_o && fault_o) |-> (mtype_o == '0));

  // R10
  pass_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pte_vld_i |=> (fault_o || (mtype_o == $past(pte_i[MT_MSB:MT_LSB]))));

endmodule

bind pte_mtype_check pte_mtype_check_sva #(
  .PTE_W     (PTE_W),
  .MT_LSB    (MT_LSB),
  .MT_W      (MT_W),
  .RSV_LSB   (RSV_LSB),
  .RSV_W     (RSV_W),
  .FEATURE_EN(FEATURE_EN)
) u_sva (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .pte_vld_i(pte_vld_i),
  .pte_i    (pte_i),
  .mt_en_i  (mt_en_i),
  .res_vld_o(res_vld_o),
  .fault_o  (fault_o),
  .leaf_o   (leaf_o),
  .mtype_o  (mtype_o)
);

// File: tb/pte_mtype_check_tb_top.sv
module pte_mtype_check_tb_top;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        pte_vld_i = 1'b0;
  logic [63:0] pte_i = '0;
  logic        mt_en_i = 1'b0;

  logic       res_vld_o, fault_o, leaf_o;
  logic [1:0] mtype_o;
  logic       off_res_vld, off_fault, off_leaf;
  logic [1:0] off_mtype;

  int tests = 0;
  int fails = 0;

  always #10 clk_i = ~clk_i;  // 50 MHz

  pte_mtype_check #(.FEATURE_EN(1'b1)) dut_i (
    .clk_i, .rst_ni, .pte_vld_i, .pte_i, .mt_en_i,
    .res_vld_o, .fault_o, .leaf_o, .mtype_o
  );

  pte_mtype_check #(.FEATURE_EN(1'b0)) dut_off_i (
    .clk_i, .rst_ni, .pte_vld_i, .pte_i, .mt_en_i,
    .res_vld_o(off_res_vld), .fault_o(off_fault),
    .leaf_o(off_leaf), .mtype_o(off_mtype)
  );

  function automatic logic [63:0] mk(input bit v, input bit r, input bit w, input bit x,
                                     input logic [1:0] mt, input logic [6:0] rsv,
                                     input logic [63:0] noise);
    logic [63:0] e;
    e = noise & ~64'h7FF0_0000_0000_000F;
    e[0] = v; e[1] = r; e[2] = w; e[3] = x;
    e[62:61] = mt;
    e[60:54] = rsv;
    return e;
  endfunction

  function automatic bit exp_fault(input logic [63:0] e, input bit en, input bit feat);
    bit leaf, f;
    leaf = e[1] | e[3];
    f = !e[0] || (e[2] && !e[1]) || (e[60:54] != 0);
    if (!feat) f = f || (e[62:61] != 0);
    else if (leaf) f = f || (e[62:61] == 2'b11) || ((e[62:61] != 0) && !en);
    else f = f || (e[62:61] != 0);
    return f;
  endfunction

  task automatic check(input string tag, input string what, input logic [3:0] got,
                       input logic [3:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s got %0h exp %0h", tag, what, got, exp);
    end
  endtask

  task automatic apply(input string tag, input logic [63:0] e, input bit en);
    bit f1, f0;
    @(negedge clk_i);
    pte_vld_i = 1'b1; pte_i = e; mt_en_i = en;
    @(negedge clk_i);
    pte_vld_i = 1'b0;
    f1 = exp_fault(e, en, 1'b1);
    f0 = exp_fault(e, en, 1'b0);
    check(tag, "res_vld", {3'b0, res_vld_o}, 4'd1);
    check(tag, "fault", {3'b0, fault_o}, {3'b0, f1});
    check(tag, "leaf", {3'b0, leaf_o}, {3'b0, e[1] | e[3]});
    check(tag, "mtype", {2'b0, mtype_o}, {2'b0, (f1 ? 2'b00 : e[62:61])});
    check(tag, "off_fault", {3'b0, off_fault}, {3'b0, f0});
    check(tag, "off_mtype", {2'b0, off_mtype}, {2'b0, (f0 ? 2'b00 : e[62:61])});
  endtask

  initial begin
    #4_000_000;
    fails++;
    $display("FAIL watchdog expired got running exp done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [63:0] n;
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk_i);
    // R1: outputs clear while in reset
    check("R1", "res_vld", {3'b0, res_vld_o}, 4'd0);
    check("R1", "fault", {3'b0, fault_o}, 4'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1", "res_vld after release", {3'b0, res_vld_o}, 4'd0);

    n = {$urandom, $urandom};
    // R3 leaf accepted, code zero
    apply("R3", mk(1, 1, 0, 0, 2'b00, 0, n), 1'b0);
    // R7 leaf with code 01 enabled, R9 faults in the off build
    apply("R7", mk(1, 1, 1, 0, 2'b01, 0, n), 1'b1);
    // R2: no strobe -> valid drops, results hold
    @(negedge clk_i);
    pte_i = ~pte_i; mt_en_i = 1'b0;
    check("R2", "res_vld idle", {3'b0, res_vld_o}, 4'd0);
    check("R2", "fault hold", {3'b0, fault_o}, 4'd0);
    check("R2", "mtype hold", {2'b0, mtype_o}, 4'd1);
    check("R2", "leaf hold", {3'b0, leaf_o}, 4'd1);
    apply("R7", mk(1, 1, 0, 1, 2'b10, 0, n), 1'b0);
    apply("R6", mk(1, 1, 1, 1, 2'b11, 0, n), 1'b1);
    apply("R8", mk(1, 0, 0, 0, 2'b01, 0, n), 1'b1);
    apply("R8", mk(1, 0, 0, 0, 2'b10, 0, n), 1'b0);
    apply("R3", mk(1, 0, 0, 0, 2'b00, 0, n), 1'b1);
    apply("R4", mk(0, 1, 0, 0, 2'b00, 0, n), 1'b1);
    apply("R4", mk(1, 0, 1, 0, 2'b00, 0, n), 1'b1);
    apply("R5", mk(1, 1, 0, 0, 2'b00, 7'h01, n), 1'b1);
    apply("R5", mk(1, 1, 0, 0, 2'b00, 7'h40, n), 1'b1);
    apply("R9", mk(1, 0, 0, 1, 2'b10, 0, n), 1'b1);
    // R10: noise bits flipped, code still passes through
    apply("R10", mk(1, 0, 0, 1, 2'b10, 0, ~n), 1'b1);

    for (int i = 0; i < 600; i++) begin
      logic [6:0] rsv;
      logic [3:0] fl;
      fl  = 4'($urandom);
      rsv = ($urandom_range(0, 3) == 0) ? 7'($urandom) : 7'd0;
      n   = {$urandom, $urandom};
      if ($urandom_range(0, 1) == 0) fl[0] = 1'b1;
      apply("R10 random", mk(fl[0], fl[1], fl[2], fl[3], 2'($urandom), rsv, n),
            1'($urandom));
      if ($urandom_range(0, 3) == 0) @(negedge clk_i);
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule